// File: doc/BRIEF.md
# Programmable SOF Microframe Timer

This block sets the start-of-frame rhythm of a high-speed USB host. It counts bit-time ticks and, at the end of each microframe, raises a one-cycle SOF strobe, advances a 3-bit microframe index and, once per eight microframes, an 11-bit frame number. The length of a microframe is not fixed. Software trims it through an 8-bit adjustment register whose low six bits select the length. Each step of that field is worth 16 bit times above a floor of 59488, so the length runs from 59488 up to 60496. After power-up the field holds 32, which gives the nominal 60000.

The adjustment register survives an ordinary reset. Only the power-on reset puts it back to its default. The counter picks up a new value only at a microframe boundary, so a microframe already under way always keeps the length it started with. A run input starts and stops the timer. While run is low the count stays at zero. The first SOF comes one full microframe after run goes high.

Top module: `sofFrameTimer`

## Requirements
- R1: With run high and steady, consecutive SOF pulses are separated by exactly BASE_LEN + STEP_LEN * adj counted ticks, where adj is the 6-bit adjustment value (59488 + 16 * adj by default).
- R2: After power-on reset the adjustment field reads 32 (0x20), and the first microframe is BASE_LEN + STEP_LEN * 32 ticks long (60000 by default).
- R3: A write stores regWrData[5:0] as the adjustment value. regRdData[5:0] returns it, and regRdData[7:6] always read 0.
- R4: The adjustment value is kept when only rstN is pulsed. Asserting rstPorN returns it to 32.
- R5: A write during a microframe does not change that microframe's length. The new length applies from the next boundary onward.
- R6: sofPulse is high for exactly one cycle. It rises in the cycle after the clock edge at which the final tick of a microframe is counted.
- R7: uframeIdx is 0 after reset and advances by one on every SOF, wrapping from 7 to 0. It does not change at any other time.
- R8: frameNum is 0 after reset and advances by one on the SOF at which uframeIdx wraps from 7 to 0, wrapping modulo 2^FRAME_W. It does not change at any other time.
- R9: While run is low, the tick count is cleared and no SOF is produced. A tick is counted only at an edge where run is high and was already high at the previous edge. The first SOF therefore appears one full microframe length after run rises.
- R10: A clock edge with tickEn low does not advance the microframe count.
- R11: Asserting rstN (or rstPorN) clears sofPulse, uframeIdx, frameNum and the tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, active low, asynchronous; also resets the adjustment register |
| rstN | input | 1 | Ordinary reset, active low, asynchronous; leaves the adjustment register alone |
| tickEn | input | 1 | One high-speed bit-time tick when high at a clock edge |
| run | input | 1 | Timer enable; low clears the count |
| regWrEn | input | 1 | Write strobe for the adjustment register |
| regWrData | input | 8 | Write data; bits 5:0 used |
| regRdData | output | 8 | Adjustment register read value; bits 7:6 zero |
| sofPulse | output | 1 | One-cycle start-of-frame strobe |
| frameNum | output | FRAME_W (11) | Frame number |
| uframeIdx | output | 3 | Microframe index within the frame |

## Verification
The bench builds the timer with BASE_LEN = 20, STEP_LEN = 2 and FRAME_W = 4, and keeps the 6-bit adjustment field and its reset value of 32. The default microframe is then 84 ticks and the longest is 146. With these values, mid-frame length changes, half-rate tick gating, run restarts and both kinds of reset can all be exercised in a short run. The frame counter also completes a full wrap through all of its 16 values.

// File: rtl/sofFrameTimerPkg.sv
package sofFrameTimerPkg;

  // Control-to-datapath strobes, one set per clock cycle.
  typedef struct packed {
    logic clearCnt;  // drop the tick count to zero
    logic countEn;   // count one tick this edge
    logic wrapEn;    // microframe boundary reached this edge
    logic loadLen;   // latch the register value as the active length
  } sofStrobes_t;

endpackage

// File: rtl/sofFrameTimerCtrl.sv
module sofFrameTimerCtrl
  import sofFrameTimerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        tickEn,
  input  logic        atEnd,
  output sofStrobes_t strobes
);

  // Set one edge after run is seen high; ticks count only once it is set.
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= run;
  end

  always_comb begin
    strobes.clearCnt = !run;
    strobes.countEn  = run && running && tickEn;
    strobes.wrapEn   = strobes.countEn && atEnd;
    strobes.loadLen  = !running || strobes.wrapEn;
  end

  // R9: a rising run never produces a boundary in the same edge
  a_r9_no_wrap_at_start: assert property (@(posedge clk) disable iff (!rstN)
    (run && !running) |-> !strobes.wrapEn);

endmodule

// File: rtl/sofFrameTimerDp.sv
module sofFrameTimerDp
  import sofFrameTimerPkg::*;
#(
  parameter int BASE_LEN  = 59488,
  parameter int STEP_LEN  = 16,
  parameter int ADJ_W     = 6,
  parameter int ADJ_RESET = 32,
  parameter int REG_W     = 8,
  parameter int FRAME_W   = 11,
  parameter int UFRAMES   = 8
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  sofStrobes_t        strobes,
  output logic               atEnd,
  output logic [REG_W-1:0]   regRdData,
  output logic               sofPulse,
  output logic [FRAME_W-1:0] frameNum,
  output logic [$clog2(UFRAMES)-1:0] uframeIdx
);

  localparam int MAX_LEN = BASE_LEN + STEP_LEN * ((1 << ADJ_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int UF_W    = $clog2(UFRAMES);

  logic [ADJ_W-1:0] adjReg;   // software-visible, sticky
  logic [ADJ_W-1:0] curAdj;   // length in force for this microframe
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curLen;
  logic [CNT_W-1:0] lastCnt;

  // Adjustment register: only power-on reset touches it.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)     adjReg <= ADJ_W'(ADJ_RESET);
    else if (regWrEn) adjReg <= regWrData[ADJ_W-1:0];
  end

  generate
    if (REG_W > ADJ_W) begin : g_padRead
      assign regRdData = {{(REG_W - ADJ_W){1'b0}}, adjReg};
    end else begin : g_fullRead
      assign regRdData = adjReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curAdj <= ADJ_W'(ADJ_RESET);
    else if (strobes.loadLen) curAdj <= adjReg;
  end

  assign curLen  = CNT_W'(BASE_LEN) + CNT_W'(STEP_LEN) * CNT_W'(curAdj);
  assign lastCnt = curLen - CNT_W'(1);
  assign atEnd   = (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cnt <= '0;
    else if (strobes.clearCnt || strobes.wrapEn) cnt <= '0;
    else if (strobes.countEn)                 cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sofPulse  <= 1'b0;
      uframeIdx <= '0;
      frameNum  <= '0;
    end else begin
      sofPulse <= strobes.wrapEn;
      if (strobes.wrapEn) begin
        if (uframeIdx == UF_W'(UFRAMES - 1)) begin
          uframeIdx <= '0;
          frameNum  <= frameNum + FRAME_W'(1);
        end else begin
          uframeIdx <= uframeIdx + UF_W'(1);
        end
      end
    end
  end

  // R1: the count never runs past the active length
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);

  // R5: the active length only changes on a load strobe
  a_r5_len_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLen |=> $stable(curAdj));

  // R6: the strobe lasts one cycle
  a_r6_sof_single: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> !sofPulse);

  // R7: index steps on SOF and holds otherwise
  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> uframeIdx == UF_W'($past(uframeIdx) + UF_W'(1)));
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sofPulse |-> $stable(uframeIdx));

  // R8: frame steps only on index wrap
  a_r8_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    (sofPulse && uframeIdx == '0) |-> frameNum == FRAME_W'($past(frameNum) + FRAME_W'(1)));
  a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(sofPulse && uframeIdx == '0) |-> $stable(frameNum));

  // R9: idle clears the count
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> cnt == '0);

endmodule

// File: rtl/sofFrameTimer.sv
module sofFrameTimer
  import sofFrameTimerPkg::*;
#(
  parameter int BASE_LEN  = 59488,
  parameter int STEP_LEN  = 16,
  parameter int ADJ_W     = 6,
  parameter int ADJ_RESET = 32,
  parameter int FRAME_W   = 11
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               run,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic               sofPulse,
  output logic [FRAME_W-1:0] frameNum,
  output logic [2:0]         uframeIdx
);

  sofStrobes_t strobes;
  logic        atEnd;
  logic        coreRstN;

  // Power-on reset also clears the timing state.
  assign coreRstN = rstN && rstPorN;

  sofFrameTimerCtrl i_ctrl (
    .clk     (clk),
    .rstN    (coreRstN),
    .run     (run),
    .tickEn  (tickEn),
    .atEnd   (atEnd),
    .strobes (strobes)
  );

  sofFrameTimerDp #(
    .BASE_LEN  (BASE_LEN),
    .STEP_LEN  (STEP_LEN),
    .ADJ_W     (ADJ_W),
    .ADJ_RESET (ADJ_RESET),
    .REG_W     (8),
    .FRAME_W   (FRAME_W),
    .UFRAMES   (8)
  ) i_dp (
    .clk       (clk),
    .rstPorN   (rstPorN),
    .rstN      (coreRstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobes   (strobes),
    .atEnd     (atEnd),
    .regRdData (regRdData),
    .sofPulse  (sofPulse),
    .frameNum  (frameNum),
    .uframeIdx (uframeIdx)
  );

endmodule

// File: tb/test_sofFrameTimer.sv
module test_sofFrameTimer;

  localparam int BASE = 20;
  localparam int STEP = 2;
  localparam int FW   = 4;

  logic clk = 1'b0;
  logic rstPorN = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic run = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sofPulse;
  logic [FW-1:0] frameNum;
  logic [2:0] uframeIdx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int mAdj = 32, mCur = 32, mCnt = 0, mIdx = 0, mFrame = 0;
  bit mSof = 0, mRunning = 0;

  always #10 clk = ~clk;

  sofFrameTimer #(.BASE_LEN(BASE), .STEP_LEN(STEP), .FRAME_W(FW)) i_sofFrameTimer (
    .clk(clk), .rstPorN(rstPorN), .rstN(rstN), .tickEn(tickEn), .run(run),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .sofPulse(sofPulse), .frameNum(frameNum), .uframeIdx(uframeIdx));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Reference model: counts ticks per microframe, lengths picked at boundaries.
  always @(posedge clk) begin
    int len;
    bit counted, boundary;
    cycles++;
    if (!rstPorN || !rstN) begin
      mCnt = 0; mIdx = 0; mFrame = 0; mSof = 0; mCur = 32; mRunning = 0;
    end else begin
      len = BASE + STEP * mCur;
      counted = run && mRunning && tickEn;
      boundary = counted && (mCnt + 1 == len);
      mSof = boundary;
      if (!run || boundary) mCnt = 0;
      else if (counted) mCnt++;
      if (boundary) begin
        mIdx++;
        if (mIdx == 8) begin mIdx = 0; mFrame = (mFrame + 1) % (1 << FW); end
      end
      if (!mRunning || boundary) mCur = mAdj;
      mRunning = run;
    end
    if (!rstPorN) mAdj = 32;
    else if (regWrEn) mAdj = regWrData & 8'h3f;
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R6 sofPulse", int'(sofPulse), int'(mSof));
      chk("R7 uframeIdx", int'(uframeIdx), mIdx);
      chk("R8 frameNum", int'(frameNum), mFrame);
      chk("R3 regRdData", int'(regRdData), mAdj);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitSof(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sofPulse && n < 5000);
  endtask

  task automatic writeAdj(input logic [7:0] v);
    regWrData = v; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    int n, prevFrame;
    bit seen;
    repeat (3) @(negedge clk);
    #1 rstPorN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R2 R11: reset state
    chk("R2 reset adj", int'(regRdData), 32);
    chk("R11 reset idx", int'(uframeIdx), 0);
    chk("R11 reset frame", int'(frameNum), 0);
    chk("R11 reset sof", int'(sofPulse), 0);

    // R9: first SOF one full period after run rises
    run = 1'b1;
    waitSof(n);
    chk("R9 first sof", n, BASE + STEP * 32 + 1);
    waitSof(n);
    chk("R1 R2 default period", n, BASE + STEP * 32);

    // R5: write mid-frame; current frame keeps its length
    writeAdj(8'h00);
    waitSof(n);
    chk("R5 old length kept", n, BASE + STEP * 32 - 1);
    waitSof(n);
    chk("R5 new length", n, BASE);

    // R3: reserved bits read zero
    writeAdj(8'hff);
    chk("R3 reserved bits", int'(regRdData), 8'h3f);
    waitSof(n);
    waitSof(n);
    chk("R1 max period", n, BASE + STEP * 63);

    // R10: ticks on alternate cycles double the period
    writeAdj(8'h05);
    waitSof(n);
    waitSof(n);
    tickEn = 1'b0; n = 0;
    do begin @(negedge clk); n++; tickEn = ~tickEn; end while (!sofPulse && n < 5000);
    tickEn = 1'b1;
    chk("R10 half-rate period", n, 2 * (BASE + STEP * 5));

    // R9: run low stops SOFs, restart takes a full period
    run = 1'b0; seen = 0;
    repeat (200) begin @(negedge clk); if (sofPulse) seen = 1; end
    chk("R9 no sof when idle", int'(seen), 0);
    run = 1'b1;
    waitSof(n);
    chk("R9 restart period", n, BASE + STEP * 5 + 1);

    // R8: full frame counter wrap with the shortest microframe
    writeAdj(8'h00);
    waitSof(n);
    prevFrame = int'(frameNum);
    repeat (140) begin
      waitSof(n);
      if (uframeIdx == 3'd0) begin
        chk("R8 frame step", int'(frameNum), (prevFrame + 1) % (1 << FW));
        prevFrame = int'(frameNum);
      end
    end

    // R4 R11: ordinary reset keeps the register, clears counters
    writeAdj(8'h2a);
    #1 rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R4 sticky adj", int'(regRdData), 8'h2a);
    chk("R11 idx cleared", int'(uframeIdx), 0);
    chk("R11 frame cleared", int'(frameNum), 0);
    waitSof(n);
    waitSof(n);
    chk("R4 sticky period", n, BASE + STEP * 42);

    // R4: power-on reset restores the default
    #1 rstPorN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1 rstPorN = 1'b1;
    @(negedge clk);
    chk("R4 por default", int'(regRdData), 32);
    waitSof(n);
    waitSof(n);
    chk("R2 default after por", n, BASE + STEP * 32);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule